// File: doc/BRIEF.md
# Idle-State Auto-Demotion Controller

This unit belongs to a single core. It sits between the idle state that the core asks for and the idle state that the power logic actually grants. It keeps a short record of how long the core's recent idle periods lasted. While that record shows only brief stays, a request for a deep state is granted as a shallower state instead. This avoids paying the entry and exit cost of a deep state that the core would leave again almost at once.

The unit offers two demotion paths, and each can be switched on by itself or together with the other. The first path turns a deepest-state request (C6) into the medium state (C3). The second path turns a deepest-state or medium-state request into the shallow state (C1). Residency is measured in clock cycles: counting runs for as long as the request is not C0. When the request returns to C0, the count is compared with a programmable threshold. A small saturating history counter then moves up after a long period and drops to zero after a short one. Once that counter reaches its goal, deep requests are granted unchanged.

Both enables pass through a register that reset clears. Demotion is therefore off coming out of reset, and requests are then granted as asked.

Top module: `idle_demote_ctrl`

## Requirements
- R1: States use a 3-bit code: C0=0, C1=1, C3=3, C6=6. While reset is high, and on the first edge after it, the granted state reads C0.
- R2: Reset clears the registered copies of both enables. While both copies are 0, every legal request is granted unchanged. A change on an enable input takes effect on the second rising edge after it.
- R3: The grant is registered. A request seen at a rising edge appears on the grant output right after that edge.
- R4: An idle period is a run of consecutive edges at which the request is not C0. Its length is the number of those edges. The period counts as long when that length is greater than or equal to the threshold; 10 is long and 9 is short for a threshold of 10.
- R5: The history counter starts at 0 after reset. Each long period raises it by one, up to HIST_GOAL (default 2), and it stays there. Each short period sets it back to 0.
- R6: With only the C6-to-C3 path enabled and the history below HIST_GOAL, a C6 request is granted C3 and a C3 request is granted C3.
- R7: With the C6/C3-to-C1 path enabled and the history below HIST_GOAL, C6 and C3 requests are granted C1.
- R8: With both paths enabled and the history below HIST_GOAL, a C6 request is granted C1.
- R9: Once the history has reached HIST_GOAL, C6 and C3 requests are granted unchanged, whatever the enables are.
- R10: C0 and C1 requests are never altered. After an idle period ends, the grant returns to C0.
- R11: Unused request codes (2, 4, 5, 7) are granted C1 and count as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_state | input | 3 | Requested idle state code |
| en_deep_to_mid | input | 1 | Enables the C6-to-C3 demotion path |
| en_to_shallow | input | 1 | Enables the C6/C3-to-C1 demotion path |
| res_threshold | input | CNT_W | Minimum idle length, in cycles, for a period to count as long |
| grant_state | output | 3 | Granted idle state code |

## Verification
The same C6 and C3 requests are repeated under four enable settings: off, C3 path only, C1 path only, and both. This shows which path takes effect and that the C1 path wins when both are on. Idle periods of 9 and 10 cycles against a threshold of 10 pin down the comparison boundary. A run of long periods broken by one short period shows that the history counter saturates and that a short period clears it. Requests for C0, C1 and unused codes check the pass-through and fallback mappings.

// File: rtl/idle_demote_pkg.sv
package idle_demote_pkg;

    typedef enum logic [2:0] {
        CS_ACTIVE = 3'd0,
        CS_LIGHT  = 3'd1,
        CS_MID    = 3'd3,
        CS_DEEP   = 3'd6
    } cstate_e;

    typedef struct packed {
        logic to_mid;
        logic to_shallow;
    } demote_cfg_t;

    // Map a raw request code onto a legal state; unknown codes fall back to C1.
    function automatic cstate_e to_cstate(input logic [2:0] code);
        case (code)
            3'd0:    return CS_ACTIVE;
            3'd1:    return CS_LIGHT;
            3'd3:    return CS_MID;
            3'd6:    return CS_DEEP;
            default: return CS_LIGHT;
        endcase
    endfunction

    // Demotion choice: the C1 path is checked first so it wins over the C3 path.
    function automatic cstate_e pick_grant(input cstate_e req,
                                           input demote_cfg_t cfg,
                                           input logic history_ok);
        if (history_ok) return req;
        case (req)
            CS_DEEP: begin
                if (cfg.to_shallow)  return CS_LIGHT;
                else if (cfg.to_mid) return CS_MID;
                else                 return CS_DEEP;
            end
            CS_MID:  return cfg.to_shallow ? CS_LIGHT : CS_MID;
            default: return req;
        endcase
    endfunction

endpackage

// File: rtl/idle_residency_meter.sv
module idle_residency_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic             exit_vld_o,
    output logic             long_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             was_idle_q;
    logic             exit_now;

    assign exit_now = was_idle_q && !idle_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            was_idle_q <= 1'b0;
            exit_vld_o <= 1'b0;
            long_o     <= 1'b0;
        end else begin
            was_idle_q <= idle_i;
            exit_vld_o <= exit_now;
            if (exit_now) long_o <= (cnt_q >= thresh_i);
            if (idle_i) begin
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    AST_EXIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        exit_vld_o |=> !exit_vld_o); // R4

    AST_EXIT_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(exit_vld_o) |-> !$past(idle_i)); // R4

endmodule

// File: rtl/demotion_history.sv
module demotion_history #(
    parameter int HIST_GOAL = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic exit_vld_i,
    input  logic long_i,
    output logic sufficient_o
);
    localparam int HW = $clog2(HIST_GOAL + 1);
    localparam logic [HW-1:0] GOAL_V = HW'(HIST_GOAL);

    logic [HW-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (exit_vld_i) begin
            if (!long_i)               hist_q <= '0;
            else if (hist_q != GOAL_V) hist_q <= hist_q + 1'b1;
        end
    end

    assign sufficient_o = (hist_q == GOAL_V);

    AST_HIST_BOUND: assert property (@(posedge clk) disable iff (rst)
        hist_q <= GOAL_V); // R5

    AST_HIST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (exit_vld_i && !long_i) |=> (hist_q == '0)); // R5

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !exit_vld_i |=> $stable(hist_q)); // R5

endmodule

// File: rtl/demote_policy.sv
module demote_policy
    import idle_demote_pkg::*;
(
    input  logic [2:0]  req_code_i,
    input  demote_cfg_t cfg_i,
    input  logic        history_ok_i,
    output cstate_e     grant_o
);
    cstate_e req_legal;

    always_comb begin
        req_legal = to_cstate(req_code_i);
        grant_o   = pick_grant(req_legal, cfg_i, history_ok_i);
    end

    always_comb begin
        AST_POLICY_NOT_DEEPER: assert (grant_o <= req_legal); // R10
    end

endmodule

// File: rtl/idle_demote_ctrl.sv
module idle_demote_ctrl
    import idle_demote_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int HIST_GOAL = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       req_state,
    input  logic             en_deep_to_mid,
    input  logic             en_to_shallow,
    input  logic [CNT_W-1:0] res_threshold,
    output logic [2:0]       grant_state
);
    demote_cfg_t cfg_q;
    cstate_e     grant_q;
    cstate_e     grant_d;
    logic        idle;
    logic        exit_vld;
    logic        long_period;
    logic        sufficient;

    assign idle = (req_state != 3'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            grant_q <= CS_ACTIVE;
        end else begin
            cfg_q.to_mid     <= en_deep_to_mid;
            cfg_q.to_shallow <= en_to_shallow;
            grant_q          <= grant_d;
        end
    end

    idle_residency_meter #(.CNT_W(CNT_W)) u_meter (
        .clk        (clk),
        .rst        (rst),
        .idle_i     (idle),
        .thresh_i   (res_threshold),
        .exit_vld_o (exit_vld),
        .long_o     (long_period)
    );

    demotion_history #(.HIST_GOAL(HIST_GOAL)) u_history (
        .clk          (clk),
        .rst          (rst),
        .exit_vld_i   (exit_vld),
        .long_i       (long_period),
        .sufficient_o (sufficient)
    );

    demote_policy u_policy (
        .req_code_i   (req_state),
        .cfg_i        (cfg_q),
        .history_ok_i (sufficient),
        .grant_o      (grant_d)
    );

    assign grant_state = grant_q;

    AST_PASS_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.to_mid && !cfg_q.to_shallow) |=>
            (grant_state == 3'($past(to_cstate(req_state))))); // R2

    AST_PASS_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        sufficient |=> (grant_state == 3'($past(to_cstate(req_state))))); // R9

    AST_SHALLOW_WINS: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.to_shallow && !sufficient && (req_state == 3'd6 || req_state == 3'd3))
            |=> (grant_state == 3'd1)); // R8

    AST_MID_ONLY: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.to_mid && !cfg_q.to_shallow && !sufficient && req_state == 3'd6)
            |=> (grant_state == 3'd3)); // R6

    AST_ACTIVE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (req_state == 3'd0) |=> (grant_state == 3'd0)); // R10

endmodule

// File: tb/idle_demote_ctrl_tb.sv
module idle_demote_ctrl_tb;
    localparam int CNT_W = 16;
    localparam int TH    = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       req_state = 3'd0;
    logic             en_deep_to_mid = 1'b0;
    logic             en_to_shallow  = 1'b0;
    logic [CNT_W-1:0] res_threshold  = CNT_W'(TH);
    logic [2:0]       grant_state;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [2:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     chk_ev;

    always #10 clk = ~clk;

    idle_demote_ctrl #(.CNT_W(CNT_W), .HIST_GOAL(2)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .req_state      (req_state),
        .en_deep_to_mid (en_deep_to_mid),
        .en_to_shallow  (en_to_shallow),
        .res_threshold  (res_threshold),
        .grant_state    (grant_state)
    );

    // Monitor: pops expected items and compares them with the grant
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (grant_state !== it.exp) begin
                    failures++;
                    $display("FAIL %s grant=%0d expected=%0d", it.tag, grant_state, it.exp);
                end
            end
        end
    end

    task automatic expect_now(input logic [2:0] exp, input string tag);
        sb_item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic set_cfg(input logic mid, input logic sh);
        @(negedge clk);
        en_deep_to_mid = mid;
        en_to_shallow  = sh;
        repeat (2) @(negedge clk);
    endtask

    // One idle period of n edges with request code st; grant checked after first edge
    task automatic idle_period(input logic [2:0] st, input int n,
                               input logic [2:0] exp, input string tag);
        @(negedge clk);
        req_state = st;
        @(negedge clk);
        expect_now(exp, tag);
        repeat (n - 1) @(negedge clk);
        req_state = 3'd0;
        @(negedge clk);
        expect_now(3'd0, "R10 back to C0");
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_now(3'd0, "R1 reset grant");
        rst = 1'b0;
        @(negedge clk);
        expect_now(3'd0, "R1 first edge after reset");

        // Enables off: pass-through
        idle_period(3'd6, 5, 3'd6, "R2 disabled C6");
        idle_period(3'd3, 5, 3'd3, "R2 disabled C3");

        // R3: registered one-cycle latency with both paths on
        set_cfg(1'b1, 1'b1);
        idle_period(3'd6, 5, 3'd1, "R8 both on C6");
        idle_period(3'd3, 5, 3'd1, "R7 both on C3");
        idle_period(3'd1, 5, 3'd1, "R10 C1 untouched");

        set_cfg(1'b1, 1'b0);
        idle_period(3'd6, 4, 3'd3, "R6 mid only C6");
        idle_period(3'd3, 4, 3'd3, "R6 mid only C3");

        set_cfg(1'b0, 1'b1);
        idle_period(3'd6, 4, 3'd1, "R7 shallow only C6");

        // Threshold boundary: two periods of exactly TH reach the goal
        set_cfg(1'b1, 1'b1);
        idle_period(3'd6, TH, 3'd1, "R4 first long");
        idle_period(3'd6, TH, 3'd1, "R5 one long not enough");
        idle_period(3'd6, 4, 3'd6, "R9 goal reached C6");
        idle_period(3'd3, 4, 3'd1, "R5 short cleared history");
        idle_period(3'd6, TH - 1, 3'd1, "R4 below threshold");
        idle_period(3'd6, TH - 1, 3'd1, "R4 nine is short");
        idle_period(3'd6, 4, 3'd1, "R4 short periods keep demoting");

        // Saturation: three long periods then a C3 request
        idle_period(3'd6, 20, 3'd1, "R5 long a");
        idle_period(3'd6, 20, 3'd1, "R5 long b");
        idle_period(3'd6, 20, 3'd6, "R9 ready long");
        idle_period(3'd3, 20, 3'd3, "R9 ready C3");
        idle_period(3'd6, 4, 3'd6, "R5 saturated still ready");
        idle_period(3'd6, 4, 3'd1, "R5 cleared after short");

        // Unused codes
        idle_period(3'd5, 4, 3'd1, "R11 code 5 both on");
        set_cfg(1'b0, 1'b0);
        idle_period(3'd2, 4, 3'd1, "R11 code 2 off");
        idle_period(3'd7, 4, 3'd1, "R11 code 7 off");

        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired grant=%0d expected=done", grant_state);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule